// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block generates the processor reset, the peripheral reset and an open-drain enable for the board-level reset line. It is started by one of two sources. The first is a software command, written with a single-cycle strobe in the fast master-clock domain. The second is a fault pulse from a watchdog, which arrives in the slow-clock domain. Each software command carries three independent select bits, one for each target, and only the targets whose bit is set are reset.

The selected internal resets assert on the master-clock edge that samples the write. The slow-clock sequencer then takes ownership of them and releases them on a slow-clock edge. The length of the external drive is programmable as a power of two of slow-clock cycles. A status flag shows that a command is in progress, and while it is set any further write is discarded. A reset-type code records the last software reset that included the processor, or the last watchdog reset.

The reset line is monitored so that a low level pulled by an outside agent is flagged as a user reset request. The low level that the block drives itself is masked, including the synchroniser latency after the drive ends.

Top module: `rst_seq_ctrl`

## Requirements
- R1: After `por_n` is released, `proc_rst_n` and `periph_rst_n` are 1, `nrst_drive` is 0, `cmd_busy` is 0, `rst_type` is 0 and `usr_rst_req` is 0.
- R2: An accepted write (`cmd_wr`=1 while `cmd_busy`=0) drives `proc_rst_n` low on the same master-clock edge if `cmd_proc`=1. It drives `periph_rst_n` low on that edge if `cmd_periph`=1. A reset whose select bit is 0 stays at 1 for the whole command.
- R3: With `cmd_ext`=1, the selected internal resets are released on the same slow-clock edge that ends the external drive. Without `cmd_ext`, they are held for at least SW_MIN_CYC (2) slow-clock cycles.
- R4: `nrst_drive` is 1 for exactly 2^(ext_len+1) slow-clock cycles when the command has `cmd_ext`=1, and it is never driven by a command with `cmd_ext`=0.
- R5: `cmd_busy` rises on the master-clock edge that accepts the write. It stays 1 for STARTUP_CYC (2) slow-clock cycles after the last asserted output is released, and then clears.
- R6: A write while `cmd_busy`=1 is discarded. It adds no reset target, it causes no external drive, and no new command runs after the current one.
- R7: A software command with `cmd_proc`=1 sets `rst_type` to 3 (software). A command with `cmd_proc`=0 leaves `rst_type` unchanged.
- R8: A `wd_fault` pulse while no watchdog reset is active asserts the processor reset for WD_CYC (2) slow-clock cycles. If `wd_proc_only`=0, it also asserts the peripheral reset for those 2 cycles and drives `nrst_drive` for 2^(ext_len+1) cycles. In both cases `rst_type` becomes 2 (watchdog).
- R9: With `wd_proc_only`=1, a watchdog reset asserts only `proc_rst_n`. `periph_rst_n` stays 1 and `nrst_drive` stays 0.
- R10: `usr_rst_req` is never 1 while `nrst_drive` is 1, nor during the synchroniser latency after the drive ends.
- R11: A low level on `nrst_pin_n` applied from outside while the block is not driving raises `usr_rst_req` within SYNC_STAGES (2) slow-clock cycles. The flag clears once the line is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Fast master clock |
| sclk | input | 1 | Slow clock used for all reset timing |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| cmd_wr | input | 1 | Command write strobe, master-clock domain |
| cmd_proc | input | 1 | Command select: processor reset |
| cmd_periph | input | 1 | Command select: peripheral reset |
| cmd_ext | input | 1 | Command select: external reset line |
| ext_len | input | EXT_LEN_W | External drive length setting n, giving 2^(n+1) slow cycles |
| wd_proc_only | input | 1 | Watchdog reset targets only the processor |
| wd_fault | input | 1 | Watchdog fault pulse, slow-clock domain |
| nrst_pin_n | input | 1 | Sensed level of the external reset line |
| proc_rst_n | output | 1 | Processor reset, active low |
| periph_rst_n | output | 1 | Peripheral reset, active low |
| nrst_drive | output | 1 | Open-drain pull-low enable for the external line |
| cmd_busy | output | 1 | Software command in progress |
| rst_type | output | 3 | Last reset type: 0 power-up, 2 watchdog, 3 software |
| usr_rst_req | output | 1 | Low level on the line not caused by the block's own drive |

## Verification
The bench builds the block with its default parameters: a 4-bit length field, two synchroniser stages, and two-cycle hold, startup and watchdog windows. The slow clock runs at one eighth of the master clock. Every combination of the three select bits is run at length settings 0 to 3, so drives of 2, 4, 8 and 16 cycles are covered. A discarded write with the complementary select bits is placed inside each command. Watchdog resets are swept over the same lengths with the processor-only option both set and cleared. An outside pull on the line is modelled next to the self-driven pulses, so both the masking and the detection of the user reset are reached.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

  typedef struct packed {
    logic proc;
    logic periph;
    logic ext;
  } rst_sel_t;

  typedef enum logic [1:0] {
    M_IDLE,
    M_WAIT,
    M_RUN
  } mstate_t;

  typedef enum logic [1:0] {
    S_IDLE,
    S_HOLD,
    S_START
  } sstate_t;

  localparam logic [2:0] RT_POWERUP  = 3'd0;
  localparam logic [2:0] RT_WATCHDOG = 3'd2;
  localparam logic [2:0] RT_SOFTWARE = 3'd3;

  // drive length in slow cycles for a length setting n: 2^(n+1)
  function automatic int unsigned ext_len_cycles(input int unsigned setting);
    return 32'd2 << setting;
  endfunction

  // counter width able to hold the longest drive length
  function automatic int unsigned len_cnt_width(input int unsigned len_w);
    return (32'd1 << len_w) + 32'd2;
  endfunction

endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RESET_VAL;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/rstc_cmd_port.sv
module rstc_cmd_port
  import rstc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     mclk,
  input  logic     rst_n,
  input  logic     cmd_wr,
  input  rst_sel_t cmd_sel,
  input  logic     seq_on_s,
  output rst_sel_t sel_q,
  output logic     busy,
  output logic     hold,
  output logic     req,
  output logic     seq_on_m,
  output logic     wr_accept
);

  mstate_t mstate;

  rstc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_seq_sync (
    .clk   (mclk),
    .rst_n (rst_n),
    .d     (seq_on_s),
    .q     (seq_on_m)
  );

  assign wr_accept = cmd_wr && (mstate == M_IDLE);

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      mstate <= M_IDLE;
      sel_q  <= '0;
    end else begin
      case (mstate)
        M_IDLE: if (wr_accept) begin
          sel_q  <= cmd_sel;
          mstate <= M_WAIT;
        end
        M_WAIT: if (seq_on_m)  mstate <= M_RUN;
        M_RUN:  if (!seq_on_m) mstate <= M_IDLE;
        default: mstate <= M_IDLE;
      endcase
    end
  end

  assign busy = (mstate != M_IDLE);
  assign hold = (mstate == M_WAIT);
  assign req  = hold;

endmodule

// File: rtl/rstc_slow_seq.sv
module rstc_slow_seq
  import rstc_pkg::*;
#(
  parameter int EXT_LEN_W   = 4,
  parameter int SYNC_STAGES = 2,
  parameter int SW_MIN_CYC  = 2,
  parameter int STARTUP_CYC = 2,
  parameter int WD_CYC      = 2
) (
  input  logic                 sclk,
  input  logic                 rst_n,
  input  logic                 req,
  input  rst_sel_t             sel,
  input  logic [EXT_LEN_W-1:0] ext_len,
  input  logic                 wd_fault,
  input  logic                 wd_proc_only,
  output logic                 seq_on,
  output logic                 s_proc,
  output logic                 s_periph,
  output logic                 wd_act,
  output logic                 wd_periph,
  output logic                 wd_po_l,
  output logic                 ext_drive,
  output logic [2:0]           rst_type,
  output logic                 sw_start,
  output logic                 wd_start,
  output logic                 ext_load
);

  localparam int unsigned CNT_W = len_cnt_width(EXT_LEN_W);
  localparam int          WD_W  = $clog2(WD_CYC + 1);

  sstate_t          state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] len_cyc;
  logic [CNT_W-1:0] ext_cnt;
  logic [CNT_W-1:0] ext_cnt_nxt;
  logic [WD_W-1:0]  wd_cnt;
  logic             req_s;
  logic             req_d;
  logic             sel_proc_l;
  logic             sel_per_l;

  rstc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_req_sync (
    .clk   (sclk),
    .rst_n (rst_n),
    .d     (req),
    .q     (req_s)
  );

  assign len_cyc  = CNT_W'(ext_len_cycles(32'(ext_len)));
  assign sw_start = req_s && !req_d && (state == S_IDLE);
  assign wd_start = wd_fault && (wd_cnt == '0);
  assign ext_load = (sw_start && sel.ext) || (wd_start && !wd_proc_only);

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) req_d <= 1'b0;
    else        req_d <= req_s;
  end

  // software sequence: hold window, then startup window, then idle
  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      sel_proc_l <= 1'b0;
      sel_per_l  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (sw_start) begin
          state      <= S_HOLD;
          sel_proc_l <= sel.proc;
          sel_per_l  <= sel.periph;
          cnt        <= sel.ext ? len_cyc : CNT_W'(SW_MIN_CYC);
        end
        S_HOLD: begin
          if (cnt == CNT_W'(1)) begin
            state <= S_START;
            cnt   <= CNT_W'(STARTUP_CYC);
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        S_START: begin
          if (cnt == CNT_W'(1)) begin
            state <= S_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign seq_on   = (state != S_IDLE);
  assign s_proc   = (state == S_HOLD) && sel_proc_l;
  assign s_periph = (state == S_HOLD) && sel_per_l;

  // watchdog window
  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      wd_cnt  <= '0;
      wd_po_l <= 1'b0;
    end else if (wd_start) begin
      wd_cnt  <= WD_W'(WD_CYC);
      wd_po_l <= wd_proc_only;
    end else if (wd_cnt != '0) begin
      wd_cnt <= wd_cnt - WD_W'(1);
    end
  end

  assign wd_act    = (wd_cnt != '0);
  assign wd_periph = wd_act && !wd_po_l;

  // shared external drive timer, registered enable
  always_comb begin
    if (ext_load)             ext_cnt_nxt = len_cyc;
    else if (ext_cnt != '0)   ext_cnt_nxt = ext_cnt - CNT_W'(1);
    else                      ext_cnt_nxt = '0;
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      ext_cnt   <= '0;
      ext_drive <= 1'b0;
    end else begin
      ext_cnt   <= ext_cnt_nxt;
      ext_drive <= (ext_cnt_nxt != '0);
    end
  end

  // reset-type code: watchdog wins a same-cycle tie
  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n)                      rst_type <= RT_POWERUP;
    else if (wd_start)               rst_type <= RT_WATCHDOG;
    else if (sw_start && sel.proc)   rst_type <= RT_SOFTWARE;
  end

endmodule

// File: rtl/rstc_pin_mon.sv
module rstc_pin_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic sclk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic drive,
  output logic self_mask,
  output logic usr_rst_req
);

  localparam int GW = $clog2(SYNC_STAGES + 1);

  logic          pin_s;
  logic          drive_d;
  logic [GW-1:0] guard;
  logic          drive_fall;

  rstc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_pin_sync (
    .clk   (sclk),
    .rst_n (rst_n),
    .d     (pin_n),
    .q     (pin_s)
  );

  assign drive_fall = drive_d && !drive;

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      drive_d <= 1'b0;
      guard   <= '0;
    end else begin
      drive_d <= drive;
      if (drive_fall)       guard <= GW'(SYNC_STAGES);
      else if (guard != '0) guard <= guard - GW'(1);
    end
  end

  assign self_mask   = drive || drive_d || (guard != '0);
  assign usr_rst_req = !pin_s && !self_mask;

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rstc_pkg::*;
#(
  parameter int EXT_LEN_W   = 4,
  parameter int SYNC_STAGES = 2,
  parameter int SW_MIN_CYC  = 2,
  parameter int STARTUP_CYC = 2,
  parameter int WD_CYC      = 2
) (
  input  logic                 mclk,
  input  logic                 sclk,
  input  logic                 por_n,
  input  logic                 cmd_wr,
  input  logic                 cmd_proc,
  input  logic                 cmd_periph,
  input  logic                 cmd_ext,
  input  logic [EXT_LEN_W-1:0] ext_len,
  input  logic                 wd_proc_only,
  input  logic                 wd_fault,
  input  logic                 nrst_pin_n,
  output logic                 proc_rst_n,
  output logic                 periph_rst_n,
  output logic                 nrst_drive,
  output logic                 cmd_busy,
  output logic [2:0]           rst_type,
  output logic                 usr_rst_req
);

  rst_sel_t cmd_sel;
  rst_sel_t sel_q;
  logic     m_hold;
  logic     m_req;
  logic     seq_on_m;
  logic     wr_accept;
  logic     seq_on;
  logic     s_proc;
  logic     s_periph;
  logic     wd_act;
  logic     wd_periph;
  logic     wd_po_l;
  logic     sw_start;
  logic     wd_start;
  logic     ext_load;
  logic     self_mask;
  logic     m_hold_proc;
  logic     m_hold_periph;

  assign cmd_sel.proc   = cmd_proc;
  assign cmd_sel.periph = cmd_periph;
  assign cmd_sel.ext    = cmd_ext;

  rstc_cmd_port #(.SYNC_STAGES(SYNC_STAGES)) u_cmd (
    .mclk      (mclk),
    .rst_n     (por_n),
    .cmd_wr    (cmd_wr),
    .cmd_sel   (cmd_sel),
    .seq_on_s  (seq_on),
    .sel_q     (sel_q),
    .busy      (cmd_busy),
    .hold      (m_hold),
    .req       (m_req),
    .seq_on_m  (seq_on_m),
    .wr_accept (wr_accept)
  );

  rstc_slow_seq #(
    .EXT_LEN_W   (EXT_LEN_W),
    .SYNC_STAGES (SYNC_STAGES),
    .SW_MIN_CYC  (SW_MIN_CYC),
    .STARTUP_CYC (STARTUP_CYC),
    .WD_CYC      (WD_CYC)
  ) u_seq (
    .sclk         (sclk),
    .rst_n        (por_n),
    .req          (m_req),
    .sel          (sel_q),
    .ext_len      (ext_len),
    .wd_fault     (wd_fault),
    .wd_proc_only (wd_proc_only),
    .seq_on       (seq_on),
    .s_proc       (s_proc),
    .s_periph     (s_periph),
    .wd_act       (wd_act),
    .wd_periph    (wd_periph),
    .wd_po_l      (wd_po_l),
    .ext_drive    (nrst_drive),
    .rst_type     (rst_type),
    .sw_start     (sw_start),
    .wd_start     (wd_start),
    .ext_load     (ext_load)
  );

  rstc_pin_mon #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
    .sclk        (sclk),
    .rst_n       (por_n),
    .pin_n       (nrst_pin_n),
    .drive       (nrst_drive),
    .self_mask   (self_mask),
    .usr_rst_req (usr_rst_req)
  );

  // fast-domain hold bridges the gap until the slow sequencer owns the reset
  assign m_hold_proc   = m_hold && sel_q.proc;
  assign m_hold_periph = m_hold && sel_q.periph;

  assign proc_rst_n   = !(m_hold_proc   || s_proc   || wd_act);
  assign periph_rst_n = !(m_hold_periph || s_periph || wd_periph);

endmodule

// File: rtl/rst_seq_ctrl_chk.sv
module rst_seq_ctrl_chk #(
  parameter int WD_CYC = 2
) (
  input logic       mclk,
  input logic       sclk,
  input logic       por_n,
  input logic       cmd_wr,
  input logic       cmd_proc,
  input logic       cmd_busy,
  input logic       proc_rst_n,
  input logic       periph_rst_n,
  input logic       nrst_drive,
  input logic       usr_rst_req,
  input logic [2:0] rst_type,
  input logic [2:0] sel_q,
  input logic       seq_on_m,
  input logic       ext_load,
  input logic       sw_start,
  input logic       wd_start,
  input logic       wd_act,
  input logic       wd_po_l,
  input logic       s_periph,
  input logic       m_hold_periph,
  input logic       sel_in_proc
);

  // R2: accepted write with processor select resets the processor next edge
  assert_proc_on_write_R2: assert property (@(posedge mclk) disable iff (!por_n)
    (cmd_wr && !cmd_busy && cmd_proc) |=> !proc_rst_n);

  // R6: a write during a command leaves the latched selects untouched
  assert_lock_sel_R6: assert property (@(posedge mclk) disable iff (!por_n)
    (cmd_busy && cmd_wr) |=> $stable(sel_q));

  // R5: slow sequence running implies the in-progress flag
  assert_busy_cover_R5: assert property (@(posedge mclk) disable iff (!por_n)
    seq_on_m |-> cmd_busy);

  // R4: external drive only starts from a selected load
  assert_ext_source_R4: assert property (@(posedge sclk) disable iff (!por_n)
    $rose(nrst_drive) |-> $past(ext_load));

  // R10: own drive never reports as a user reset
  assert_no_self_user_R10: assert property (@(posedge sclk) disable iff (!por_n)
    nrst_drive |-> !usr_rst_req);

  // R7: software command without processor select keeps the code
  assert_type_kept_R7: assert property (@(posedge sclk) disable iff (!por_n)
    (sw_start && !sel_in_proc && !wd_start) |=> $stable(rst_type));

  // R7: software command with processor select writes code 3
  assert_type_soft_R7: assert property (@(posedge sclk) disable iff (!por_n)
    (sw_start && sel_in_proc && !wd_start) |=> (rst_type == 3'd3));

  // R9: processor-only watchdog leaves the peripheral reset alone
  assert_po_periph_R9: assert property (@(posedge sclk) disable iff (!por_n)
    (wd_act && wd_po_l && !s_periph && !m_hold_periph) |-> periph_rst_n);

  // R8: watchdog window length
  generate
    if (WD_CYC == 2) begin : g_wd2
      assert_wd_len_R8: assert property (@(posedge sclk) disable iff (!por_n)
        $rose(wd_act) |=> (wd_act ##1 !wd_act));
    end else begin : g_wdn
      assert_wd_len_R8: assert property (@(posedge sclk) disable iff (!por_n)
        $rose(wd_act) |=> wd_act);
    end
  endgenerate

endmodule

bind rst_seq_ctrl rst_seq_ctrl_chk #(.WD_CYC(WD_CYC)) u_chk (
  .mclk          (mclk),
  .sclk          (sclk),
  .por_n         (por_n),
  .cmd_wr        (cmd_wr),
  .cmd_proc      (cmd_proc),
  .cmd_busy      (cmd_busy),
  .proc_rst_n    (proc_rst_n),
  .periph_rst_n  (periph_rst_n),
  .nrst_drive    (nrst_drive),
  .usr_rst_req   (usr_rst_req),
  .rst_type      (rst_type),
  .sel_q         (sel_q),
  .seq_on_m      (seq_on_m),
  .ext_load      (ext_load),
  .sw_start      (sw_start),
  .wd_start      (wd_start),
  .wd_act        (wd_act),
  .wd_po_l       (wd_po_l),
  .s_periph      (s_periph),
  .m_hold_periph (m_hold_periph),
  .sel_in_proc   (sel_q[2])
);

// File: tb/sim_rst_seq_ctrl.sv
module sim_rst_seq_ctrl;

  localparam int CLK_PERIOD  = 10;
  localparam int SLOW_DIV    = 8;
  localparam int EXT_LEN_W   = 4;
  localparam int STARTUP_EXP = 2;
  localparam int SW_MIN_EXP  = 2;
  localparam int WD_EXP      = 2;
  localparam int LIMIT_CYC   = 150000;

  logic                 mclk = 1'b0;
  logic                 sclk = 1'b0;
  logic                 por_n = 1'b0;
  logic                 cmd_wr = 1'b0;
  logic                 cmd_proc = 1'b0;
  logic                 cmd_periph = 1'b0;
  logic                 cmd_ext = 1'b0;
  logic [EXT_LEN_W-1:0] ext_len = '0;
  logic                 wd_proc_only = 1'b0;
  logic                 wd_fault = 1'b0;
  logic                 ext_push = 1'b0;
  logic                 nrst_pin_n;
  logic                 proc_rst_n;
  logic                 periph_rst_n;
  logic                 nrst_drive;
  logic                 cmd_busy;
  logic [2:0]           rst_type;
  logic                 usr_rst_req;

  int n_chk = 0;
  int n_fail = 0;
  int self_viol = 0;
  int quiet = 0;
  int exp_type = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) mclk = ~mclk;
  always #(CLK_PERIOD*SLOW_DIV/2) sclk = ~sclk;

  // open-drain line with pull-up: low if the block or an outside agent pulls
  assign nrst_pin_n = !(nrst_drive || ext_push);

  rst_seq_ctrl #(.EXT_LEN_W(EXT_LEN_W)) u0 (
    .mclk         (mclk),
    .sclk         (sclk),
    .por_n        (por_n),
    .cmd_wr       (cmd_wr),
    .cmd_proc     (cmd_proc),
    .cmd_periph   (cmd_periph),
    .cmd_ext      (cmd_ext),
    .ext_len      (ext_len),
    .wd_proc_only (wd_proc_only),
    .wd_fault     (wd_fault),
    .nrst_pin_n   (nrst_pin_n),
    .proc_rst_n   (proc_rst_n),
    .periph_rst_n (periph_rst_n),
    .nrst_drive   (nrst_drive),
    .cmd_busy     (cmd_busy),
    .rst_type     (rst_type),
    .usr_rst_req  (usr_rst_req)
  );

  task automatic check_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // R10 monitor: user flag during own drive or the latency after it
  always @(negedge sclk) begin
    if (nrst_drive) quiet <= 4;
    else if (quiet > 0) quiet <= quiet - 1;
    if ((nrst_drive || quiet > 0) && usr_rst_req) self_viol <= self_viol + 1;
  end

  task automatic run_wd(input int len, input bit po);
    int lcyc;
    int proc_n;
    int per_n;
    int drv_n;
    lcyc   = 2 << len;
    proc_n = 0;
    per_n  = 0;
    drv_n  = 0;
    ext_len      = EXT_LEN_W'(len);
    wd_proc_only = po;
    @(negedge sclk);
    wd_fault = 1'b1;
    @(negedge sclk);
    wd_fault = 1'b0;
    for (int k = 0; k < lcyc + 6; k++) begin
      if (!proc_rst_n)   proc_n++;
      if (!periph_rst_n) per_n++;
      if (nrst_drive)    drv_n++;
      @(negedge sclk);
    end
    exp_type = 2;
    check_eq("R8 watchdog processor reset cycles", proc_n, WD_EXP);
    if (po) begin
      check_eq("R9 proc-only peripheral reset cycles", per_n, 0);
      check_eq("R9 proc-only external drive cycles", drv_n, 0);
    end else begin
      check_eq("R8 watchdog peripheral reset cycles", per_n, WD_EXP);
      check_eq("R8 watchdog external drive cycles", drv_n, lcyc);
    end
    check_eq("R8 reset type after watchdog", int'(rst_type), exp_type);
  endtask

  task automatic run_sw(input int len, input bit p, input bit q, input bit e);
    int  lcyc;
    int  drv_n;
    int  proc_n;
    int  per_n;
    int  post_n;
    int  tries;
    bit  seen;
    bit  locked;
    bit  prev_drv;
    bit  prev_proc;
    lcyc   = 2 << len;
    drv_n  = 0;
    proc_n = 0;
    per_n  = 0;
    post_n = 0;
    tries  = 0;
    seen   = 1'b0;
    locked = 1'b0;
    prev_drv  = 1'b0;
    prev_proc = !p;
    ext_len = EXT_LEN_W'(len);
    @(negedge mclk);
    cmd_proc   = p;
    cmd_periph = q;
    cmd_ext    = e;
    cmd_wr     = 1'b1;
    @(negedge mclk);
    cmd_wr = 1'b0;
    check_eq("R5 busy on accepting edge", int'(cmd_busy), 1);
    check_eq("R2 processor reset on write", int'(proc_rst_n), int'(!p));
    check_eq("R2 peripheral reset on write", int'(periph_rst_n), int'(!q));
    while (1) begin
      @(negedge sclk);
      if (!cmd_busy) break;
      tries++;
      if (tries > 200) begin
        check_eq("R5 busy never cleared", 1, 0);
        break;
      end
      if (nrst_drive)    drv_n++;
      if (!proc_rst_n)   proc_n++;
      if (!periph_rst_n) per_n++;
      if (prev_drv && !nrst_drive) begin
        check_eq("R3 processor released with drive end", int'(proc_rst_n), 1);
        check_eq("R3 peripheral released with drive end", int'(periph_rst_n), 1);
        check_eq("R3 processor held up to drive end", int'(prev_proc), int'(!p));
      end
      if (!proc_rst_n || !periph_rst_n || nrst_drive) seen = 1'b1;
      else if (seen) post_n++;
      prev_drv  = nrst_drive;
      prev_proc = proc_rst_n;
      if (!locked) begin
        locked = 1'b1;
        @(negedge mclk);
        cmd_proc   = !p;
        cmd_periph = !q;
        cmd_ext    = !e;
        cmd_wr     = 1'b1;
        @(negedge mclk);
        cmd_wr = 1'b0;
      end
    end
    check_eq("R4 external drive cycles", drv_n, e ? lcyc : 0);
    if (!q) check_eq("R6 peripheral untouched by locked write", per_n, 0);
    if (p) begin
      n_chk++;
      if (proc_n < (e ? lcyc : SW_MIN_EXP)) begin
        n_fail++;
        $display("FAIL R3 processor hold cycles actual=%0d expected>=%0d",
                 proc_n, e ? lcyc : SW_MIN_EXP);
      end
    end else begin
      check_eq("R2 processor untouched without select", proc_n, 0);
    end
    if (p || q || e) check_eq("R5 startup cycles after release", post_n, STARTUP_EXP);
    if (p) exp_type = 3;
    check_eq("R7 reset type after software command", int'(rst_type), exp_type);
    for (int k = 0; k < 20; k++) @(negedge sclk);
    check_eq("R6 no command after locked write: busy", int'(cmd_busy), 0);
    check_eq("R6 no command after locked write: drive", int'(nrst_drive), 0);
    check_eq("R6 no command after locked write: processor", int'(proc_rst_n), 1);
  endtask

  initial begin
    repeat (4) @(negedge mclk);
    por_n = 1'b1;
    @(negedge sclk);
    @(negedge sclk);
    check_eq("R1 reset proc_rst_n", int'(proc_rst_n), 1);
    check_eq("R1 reset periph_rst_n", int'(periph_rst_n), 1);
    check_eq("R1 reset nrst_drive", int'(nrst_drive), 0);
    check_eq("R1 reset cmd_busy", int'(cmd_busy), 0);
    check_eq("R1 reset rst_type", int'(rst_type), 0);
    check_eq("R1 reset usr_rst_req", int'(usr_rst_req), 0);

    for (int len = 0; len < 4; len++) begin
      run_wd(len, 1'b1);
      run_wd(len, 1'b0);
    end

    for (int len = 0; len < 4; len++) begin
      for (int b = 0; b < 8; b++) begin
        run_sw(len, b[2], b[1], b[0]);
      end
    end

    // R11: outside pull on the line while idle
    for (int k = 0; k < 6; k++) @(negedge sclk);
    ext_push = 1'b1;
    @(negedge sclk);
    @(negedge sclk);
    check_eq("R11 user reset seen", int'(usr_rst_req), 1);
    @(negedge sclk);
    ext_push = 1'b0;
    for (int k = 0; k < 4; k++) @(negedge sclk);
    check_eq("R11 user reset clears", int'(usr_rst_req), 0);

    check_eq("R10 user flag during own drive", self_viol, 0);
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (LIMIT_CYC) @(posedge mclk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog timeout actual=%0d expected=%0d", LIMIT_CYC, 0);
      finish_run();
    end
  end

endmodule